// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address. It does so by reading a two-level translation table in memory. A client presents a virtual address together with the base address of the first-level table. The walker then issues one or two 32-bit descriptor reads on a simple valid/ready read port and decodes what comes back.

A first-level descriptor either maps a whole 1 MiB section directly or points to a second-level table. A second-level descriptor maps either a 64 KiB large page or a 4 KiB small page. Each page size keeps a different number of descriptor bits as the physical base and takes the remaining low bits from the virtual address. A descriptor whose type marks it as invalid ends the walk with a fault. A fault returns the virtual address that failed and the table level at which it failed, and no physical address.

The walker handles one translation at a time. It accepts a new request only after the previous result has been taken. Results are not cached and access rights are not checked.

Top module: `iova_walker`

## Requirements
- R1: After a clock edge with `rst_n` low, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first read address is the table base captured at request acceptance plus four times virtual address bits [31:20]. Later changes on `req_base` do not affect a walk in flight.
- R3: A first-level descriptor of type 2 (bits [1:0]) completes the walk after that single read. It returns `rsp_kind` = 1 and `rsp_paddr` = {descriptor[31:20], vaddr[19:0]}, with `rsp_fault` = 0 and `rsp_fault_addr` = 0.
- R4: A first-level descriptor of type 1 causes a second read at {descriptor[31:10], vaddr[19:12], 2'b00}. Descriptor bits [9:2] are ignored.
- R5: A second-level descriptor with bit 1 set (type 2 or 3) is a small page. The walk returns `rsp_kind` = 3 and `rsp_paddr` = {descriptor[31:12], vaddr[11:0]}.
- R6: A second-level descriptor of type 1 is a large page. The walk returns `rsp_kind` = 2 and `rsp_paddr` = {descriptor[31:16], vaddr[15:0]}. Descriptor bits [15:2] are ignored.
- R7: A first-level descriptor of type 0 or 3 ends the walk after one read. It returns `rsp_fault` = 1, `rsp_fault_lvl` = 0, `rsp_fault_addr` = the virtual address, `rsp_paddr` = 0 and `rsp_kind` = 0.
- R8: A second-level descriptor of type 0 returns `rsp_fault` = 1, `rsp_fault_lvl` = 1, `rsp_fault_addr` = the virtual address, `rsp_paddr` = 0 and `rsp_kind` = 0.
- R9: `req_ready` is 0 from the acceptance of a request until the cycle after its result is taken (`rsp_valid` and `rsp_ready` both high). While `rsp_valid` is high and `rsp_ready` is low, all result fields hold.
- R10: `mem_req_valid` stays high with a stable address until `mem_req_ready`. At most one read is outstanding, no read is issued while a result is pending, and the walker waits for `mem_rsp_valid` before it continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base address |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Walk ended in a translation fault |
| rsp_fault_lvl | output | 1 | Fault level: 0 first, 1 second |
| rsp_kind | output | 2 | 0 none, 1 section, 2 large page, 3 small page |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault_addr | output | 32 | Faulting virtual address, 0 on success |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 1 MiB section shift, a 64 KiB large-page shift and a 4 KiB small-page shift. Under these values every descriptor type at both levels can be reached from a small sparse memory. That memory holds descriptors with junk in their ignored low bits, the last first-level entry, and a second table pointer to the same second-level table. Two different table bases give different results for one address. Random memory stalls, random response latency and random result back-pressure exercise the handshake rules, and the base input is scrambled during every walk.

// File: rtl/walk_pkg.sv
// Shared types for the translation walker.
// Assumes: descriptor type lives in bits [1:0] of every descriptor.
package walk_pkg;

    // Kind of mapping that a finished walk reports.
    typedef enum logic [1:0] {
        PK_NONE    = 2'd0,
        PK_SECTION = 2'd1,
        PK_LARGE   = 2'd2,
        PK_SMALL   = 2'd3
    } page_kind_e;

    // Meaning of a first-level descriptor.
    typedef enum logic [1:0] {
        L1_FAULT   = 2'd0,
        L1_SECTION = 2'd1,
        L1_TABLE   = 2'd2
    } l1_kind_e;

    // Walk sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_L1_ISSUE = 3'd1,
        ST_L1_WAIT  = 3'd2,
        ST_L2_ISSUE = 3'd3,
        ST_L2_WAIT  = 3'd4,
        ST_DONE     = 3'd5
    } walk_state_e;

endpackage

// File: rtl/walk_addr_gen.sv
// Descriptor address generator.
// Forms the first-level entry address from the captured base and the top
// virtual address bits, and the second-level entry address from the stored
// first-level descriptor and the middle virtual address bits.
// Assumes: SPAGE_SHIFT < SECT_SHIFT < ADDR_W; entries are 4 bytes.
module walk_addr_gen #(
    parameter int ADDR_W      = 32,
    parameter int SECT_SHIFT  = 20,
    parameter int SPAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] base_q,
    input  logic [ADDR_W-1:0] va_q,
    input  logic [ADDR_W-1:0] l1_desc_q,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] l2_addr
);
    localparam int L2_IDX_W = SECT_SHIFT - SPAGE_SHIFT;
    localparam int L2_ALIGN = L2_IDX_W + 2;
    localparam logic [ADDR_W-1:0] ONES       = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] L2TAB_MASK = ONES << L2_ALIGN;
    localparam logic [ADDR_W-1:0] SECT_LOW   = ~(ONES << SECT_SHIFT);

    // First-level entry: base plus word index taken from the top bits.
    always_comb begin
        l1_addr = base_q + ((va_q >> SECT_SHIFT) << 2);
    end

    // Second-level entry: aligned table base merged with the word index.
    always_comb begin
        l2_addr = (l1_desc_q & L2TAB_MASK)
                | (((va_q & SECT_LOW) >> SPAGE_SHIFT) << 2);
    end
endmodule

// File: rtl/walk_l1_decode.sv
// First-level descriptor decoder.
// Classifies the descriptor as section, table pointer or fault and forms
// the section physical address.
// Assumes: type 2 = section, type 1 = table, types 0 and 3 = fault.
module walk_l1_decode
    import walk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SECT_SHIFT = 20
) (
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output l1_kind_e          kind,
    output logic [ADDR_W-1:0] sect_pa
);
    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_SHIFT;

    // Type field classification.
    always_comb begin
        unique case (desc[1:0])
            2'b10:   kind = L1_SECTION;
            2'b01:   kind = L1_TABLE;
            default: kind = L1_FAULT;
        endcase
    end

    // Section base merged with the in-section offset.
    always_comb begin
        sect_pa = (desc & SECT_MASK) | (va & ~SECT_MASK);
    end
endmodule

// File: rtl/walk_l2_decode.sv
// Second-level descriptor decoder.
// Classifies the descriptor as small page, large page or fault and forms
// the physical address with the size-specific base mask.
// Assumes: bit 1 set = small page, type 1 = large page, type 0 = fault.
module walk_l2_decode
    import walk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LPAGE_SHIFT = 16,
    parameter int SPAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output page_kind_e        kind,
    output logic [ADDR_W-1:0] page_pa
);
    localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LP_MASK = ONES << LPAGE_SHIFT;
    localparam logic [ADDR_W-1:0] SP_MASK = ONES << SPAGE_SHIFT;

    // Small pages take priority over the large-page code.
    always_comb begin
        if (desc[1]) begin
            kind    = PK_SMALL;
            page_pa = (desc & SP_MASK) | (va & ~SP_MASK);
        end else if (desc[0]) begin
            kind    = PK_LARGE;
            page_pa = (desc & LP_MASK) | (va & ~LP_MASK);
        end else begin
            kind    = PK_NONE;
            page_pa = '0;
        end
    end
endmodule

// File: rtl/walk_ctrl.sv
// Walk sequencer.
// Accepts one request at a time, issues descriptor reads, captures the
// decoded outcome and holds the result until the client takes it.
// Assumes: memory returns exactly one response per accepted read.
module walk_ctrl
    import walk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic [ADDR_W-1:0] l1_addr,
    input  logic [ADDR_W-1:0] l2_addr,
    input  l1_kind_e          l1_kind,
    input  logic [ADDR_W-1:0] sect_pa,
    input  page_kind_e        l2_kind,
    input  logic [ADDR_W-1:0] page_pa,
    output logic [ADDR_W-1:0] va_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] l1_desc_q,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic              rsp_fault_lvl,
    output logic [1:0]        rsp_kind,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_fault_addr
);
    walk_state_e state;

    // Handshake outputs decoded from the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        rsp_valid     = (state == ST_DONE);
        mem_req_valid = (state == ST_L1_ISSUE) || (state == ST_L2_ISSUE);
        mem_req_addr  = (state == ST_L2_ISSUE) ? l2_addr : l1_addr;
    end

    // State sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            va_q           <= '0;
            base_q         <= '0;
            l1_desc_q      <= '0;
            rsp_fault      <= 1'b0;
            rsp_fault_lvl  <= 1'b0;
            rsp_kind       <= PK_NONE;
            rsp_paddr      <= '0;
            rsp_fault_addr <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        base_q <= req_base;
                        state  <= ST_L1_ISSUE;
                    end
                end
                ST_L1_ISSUE: begin
                    if (mem_req_ready) state <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        l1_desc_q <= mem_rsp_data;
                        unique case (l1_kind)
                            L1_SECTION: begin
                                rsp_fault      <= 1'b0;
                                rsp_fault_lvl  <= 1'b0;
                                rsp_kind       <= PK_SECTION;
                                rsp_paddr      <= sect_pa;
                                rsp_fault_addr <= '0;
                                state          <= ST_DONE;
                            end
                            L1_TABLE: begin
                                state <= ST_L2_ISSUE;
                            end
                            default: begin
                                rsp_fault      <= 1'b1;
                                rsp_fault_lvl  <= 1'b0;
                                rsp_kind       <= PK_NONE;
                                rsp_paddr      <= '0;
                                rsp_fault_addr <= va_q;
                                state          <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_L2_ISSUE: begin
                    if (mem_req_ready) state <= ST_L2_WAIT;
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_kind <= l2_kind;
                        state    <= ST_DONE;
                        if (l2_kind == PK_NONE) begin
                            rsp_fault      <= 1'b1;
                            rsp_fault_lvl  <= 1'b1;
                            rsp_paddr      <= '0;
                            rsp_fault_addr <= va_q;
                        end else begin
                            rsp_fault      <= 1'b0;
                            rsp_fault_lvl  <= 1'b0;
                            rsp_paddr      <= page_pa;
                            rsp_fault_addr <= '0;
                        end
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iova_walker.sv
// Two-level I/O address translation walker, top level.
// Wires the sequencer to the address generator and the two decoders.
// Assumes: default geometry of 1 MiB sections, 64 KiB and 4 KiB pages.
module iova_walker
    import walk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SECT_SHIFT  = 20,
    parameter int LPAGE_SHIFT = 16,
    parameter int SPAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic              rsp_fault_lvl,
    output logic [1:0]        rsp_kind,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_fault_addr
);
    logic [ADDR_W-1:0] va_q, base_q, l1_desc_q;
    logic [ADDR_W-1:0] l1_addr, l2_addr, sect_pa, page_pa;
    l1_kind_e          l1_kind;
    page_kind_e        l2_kind;

    walk_addr_gen #(
        .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .SPAGE_SHIFT(SPAGE_SHIFT)
    ) u_addr (
        .base_q(base_q), .va_q(va_q), .l1_desc_q(l1_desc_q),
        .l1_addr(l1_addr), .l2_addr(l2_addr)
    );

    walk_l1_decode #(
        .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT)
    ) u_l1 (
        .desc(mem_rsp_data), .va(va_q), .kind(l1_kind), .sect_pa(sect_pa)
    );

    walk_l2_decode #(
        .ADDR_W(ADDR_W), .LPAGE_SHIFT(LPAGE_SHIFT), .SPAGE_SHIFT(SPAGE_SHIFT)
    ) u_l2 (
        .desc(mem_rsp_data), .va(va_q), .kind(l2_kind), .page_pa(page_pa)
    );

    walk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_base(req_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .l1_addr(l1_addr), .l2_addr(l2_addr),
        .l1_kind(l1_kind), .sect_pa(sect_pa),
        .l2_kind(l2_kind), .page_pa(page_pa),
        .va_q(va_q), .base_q(base_q), .l1_desc_q(l1_desc_q),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
        .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr),
        .rsp_fault_addr(rsp_fault_addr)
    );
endmodule

// File: rtl/walk_checker.sv
// Protocol and result-shape properties for the walker, bound to the top.
// Assumes: port names identical to the top module.
module walk_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [ADDR_W-1:0] req_base,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [ADDR_W-1:0] mem_rsp_data,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_fault,
    input logic              rsp_fault_lvl,
    input logic [1:0]        rsp_kind,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [ADDR_W-1:0] rsp_fault_addr
);
    // Read request held with a stable address until accepted.
    p_memreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // No read while a result is pending.
    p_no_read_in_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && rsp_valid));

    // Busy walker never offers to accept.
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    // Unconsumed result holds.
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_fault) && $stable(rsp_kind)
            && $stable(rsp_fault_addr) && $stable(rsp_fault_lvl));

    // A fault carries no physical address and no page kind.
    p_fault_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0 && rsp_kind == 2'd0);

    // A success names a page kind and no faulting address.
    p_success_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_kind != 2'd0 && rsp_fault_addr == '0
            && !rsp_fault_lvl);
endmodule

bind iova_walker walk_checker #(.ADDR_W(ADDR_W)) u_walk_chk (.*);

// File: tb/sim_iova_walker.sv
module sim_iova_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [31:0] req_vaddr, req_base;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid, rsp_ready, rsp_fault, rsp_fault_lvl;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_paddr, rsp_fault_addr;

    always #4 clk = ~clk;

    iova_walker u0 (.*);

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [logic [31:0]];

    localparam int NV = 11;
    localparam int NPASS = 3;
    logic [31:0] tv_va [NV];
    logic [31:0] tv_base [NV];

    logic [31:0] exp_a [$];
    string       exp_t [$];
    logic        e_fault, e_lvl;
    logic [1:0]  e_kind;
    logic [31:0] e_pa, e_fa;
    string       e_tag;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural translation model: fills address queue and expected result.
    task automatic model(input logic [31:0] va, input logic [31:0] base);
        logic [31:0] a1, a2, d1, d2;
        a1 = base + (va >> 20) * 4;
        d1 = rd(a1);
        exp_a.push_back(a1); exp_t.push_back("R2");
        e_fault = 0; e_lvl = 0; e_kind = 0; e_pa = 0; e_fa = 0;
        if (d1[1:0] == 2'd2) begin
            e_kind = 1; e_pa = {d1[31:20], va[19:0]}; e_tag = "R3";
        end else if (d1[1:0] == 2'd1) begin
            a2 = {d1[31:10], va[19:12], 2'b00};
            exp_a.push_back(a2); exp_t.push_back("R4");
            d2 = rd(a2);
            if (d2[1]) begin
                e_kind = 3; e_pa = {d2[31:12], va[11:0]}; e_tag = "R5";
            end else if (d2[0]) begin
                e_kind = 2; e_pa = {d2[31:16], va[15:0]}; e_tag = "R6";
            end else begin
                e_fault = 1; e_lvl = 1; e_fa = va; e_tag = "R8";
            end
        end else begin
            e_fault = 1; e_fa = va; e_tag = "R7";
        end
    endtask

    initial begin
        logic [31:0] ba, bb, tt;
        bit busy, pending;
        int cnt, issued, cyc;
        logic [31:0] paddr;
        logic obs_req_ready, obs_mvalid, obs_rvalid;
        logic [31:0] obs_maddr;

        ba = 32'h0010_0000; bb = 32'h0020_0000; tt = 32'h0030_0400;
        mem[ba + 4]      = 32'hABC0_0002;
        mem[ba + 8]      = 32'h0030_0401;
        mem[ba + 12]     = 32'h0000_0003;
        mem[ba + 20]     = 32'hFFF8_1232;
        mem[ba + 24]     = 32'h0030_07FD;
        mem[ba + 32'h3FFC] = 32'h0000_0002;
        mem[bb + 4]      = 32'h1110_0002;
        mem[tt + 5*4]    = 32'h1234_5002;
        mem[tt + 6*4]    = 32'h5555_6003;
        mem[tt + 32'h12*4] = 32'h7777_ABC1;

        tv_va[0] = 32'h0012_3456; tv_base[0] = ba;
        tv_va[1] = 32'h0020_5ABC; tv_base[1] = ba;
        tv_va[2] = 32'h0020_6FFF; tv_base[2] = ba;
        tv_va[3] = 32'h0021_2345; tv_base[3] = ba;
        tv_va[4] = 32'h0020_7000; tv_base[4] = ba;
        tv_va[5] = 32'h0030_0000; tv_base[5] = ba;
        tv_va[6] = 32'h0040_0010; tv_base[6] = ba;
        tv_va[7] = 32'h0010_0001; tv_base[7] = bb;
        tv_va[8] = 32'h005F_FFFF; tv_base[8] = ba;
        tv_va[9] = 32'h0060_5000; tv_base[9] = ba;
        tv_va[10] = 32'hFFF0_0000; tv_base[10] = ba;

        rst_n = 0; req_valid = 0; req_vaddr = 0; req_base = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; rsp_ready = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", {31'b0, req_ready}, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", {31'b0, rsp_valid}, 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", {31'b0, mem_req_valid}, 0);
        rst_n = 1;

        busy = 0; pending = 0; cnt = 0; issued = 0; cyc = 0; paddr = 0;
        while (issued < NV * NPASS || busy) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++; checks++;
                $display("FAIL R9 watchdog: actual=%h expected=%h", cyc, 20000);
                break;
            end
            obs_req_ready = req_ready;
            obs_mvalid    = mem_req_valid;
            obs_maddr     = mem_req_addr;
            obs_rvalid    = rsp_valid;

            // R9: acceptance only when no walk is in progress
            check(obs_req_ready == !busy, "R9", "req_ready", {31'b0, obs_req_ready}, {31'b0, !busy});
            // R10: reads only while the model expects one
            if (obs_mvalid)
                check(exp_a.size() > 0 && !pending, "R10", "unexpected read",
                      obs_maddr, 32'h0);

            // memory response
            if (pending && cnt == 0) begin
                mem_rsp_valid = 1; mem_rsp_data = rd(paddr); pending = 0;
            end else begin
                if (pending) cnt--;
                mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
            end
            // memory request acceptance
            mem_req_ready = !pending && ($urandom_range(0, 2) != 0);
            if (obs_mvalid && mem_req_ready && exp_a.size() > 0) begin
                logic [31:0] ea;
                string et;
                ea = exp_a.pop_front(); et = exp_t.pop_front();
                check(obs_maddr == ea, et, "read address", obs_maddr, ea);
                pending = 1; cnt = $urandom_range(0, 2); paddr = obs_maddr;
            end

            // result consumption
            rsp_ready = ($urandom_range(0, 1) != 0);
            if (obs_rvalid && rsp_ready) begin
                check(busy, "R9", "result without walk", {31'b0, obs_rvalid}, 0);
                check(rsp_fault == e_fault, e_tag, "fault", {31'b0, rsp_fault}, {31'b0, e_fault});
                check(rsp_fault_lvl == e_lvl, e_tag, "fault level", {31'b0, rsp_fault_lvl}, {31'b0, e_lvl});
                check(rsp_kind == e_kind, e_tag, "kind", {30'b0, rsp_kind}, {30'b0, e_kind});
                check(rsp_paddr == e_pa, e_tag, "paddr", rsp_paddr, e_pa);
                check(rsp_fault_addr == e_fa, e_tag, "fault addr", rsp_fault_addr, e_fa);
                check(exp_a.size() == 0, e_tag, "reads left", exp_a.size(), 0);
                busy = 0;
            end

            // request side: real request when idle, junk while busy
            if (obs_req_ready && issued < NV * NPASS && $urandom_range(0, 3) != 0) begin
                req_valid = 1;
                req_vaddr = tv_va[issued % NV];
                req_base  = tv_base[issued % NV];
                model(req_vaddr, req_base);
                busy = 1;
                issued++;
            end else begin
                req_valid = !obs_req_ready && ($urandom_range(0, 1) != 0);
                req_vaddr = $urandom;
                req_base  = $urandom;
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule